// File: doc/BRIEF.md
# Trap and Privilege Mode Controller

This block holds the architectural state of a small processor built to host virtual machines: a privilege mode, an instruction pointer, and a relocation segment made of a base and a length. For every instruction that the decoder offers, the block checks two things. It checks any memory reference against the segment, and it checks any attempt to rewrite processor state against the current privilege. It then either retires the instruction or takes a trap.

A trap stores the whole pre-instruction state in memory cell 0 and loads the handler's instruction pointer and segment from memory cell 1. The handler runs one privilege level above the mode that trapped. A guest operating system in supervisor mode that touches privileged state therefore lands in root mode, where a monitor runs. A user program that does the same lands in supervisor mode. A return operation reloads the full saved state from cell 0. A two-bit syndrome keeps the cause of the most recent trap, so a handler can read it without decoding the guest.

Decode, the datapath and the memory array are outside the block. They reach it only through the request port and a single-cycle memory port.

Top module: `tpc_top`

## Requirements
- R1: After a synchronous reset the mode is root (2'b10), the instruction pointer is 0, the base is 0, the length is 16'hFFFF, the syndrome is 0 and busy is low.
- R2: An accepted request that does not trap, with op 2'b00 or 2'b11 (plain execute), advances the pointer by one on the next edge and leaves the mode and segment unchanged.
- R3: When req_mem is high, an offset at or above the segment length raises a memory-protection trap. Otherwise phys_ok is high in the same cycle, and phys_addr equals base plus offset modulo 2^16.
- R4: Mode codes are 00 user, 01 supervisor, 10 root and 11 reserved. A state write (op 2'b01) traps as a control fault in user mode, in supervisor mode unless the new mode is user, and in root mode only when the new mode is reserved. A state write that succeeds loads the new mode, base and length and advances the pointer. The mode never holds the reserved code.
- R5: The trap output is high in the request cycle if either cause is present. The syndrome records both causes at once (bit 0 memory, bit 1 control) and holds them until the next trap.
- R6: In the cycle after a trapping request, the memory port writes cell 0 with the pre-instruction state. In the next cycle it reads cell 1. No other cell is ever written.
- R7: The handler state takes its pointer, base and length from cell 1. Its mode is one level above the trapping mode (user to supervisor, supervisor or root to root), and the mode field of cell 1 is ignored.
- R8: Busy is high from the cycle after a trap or return is accepted until the state is loaded. Requests offered while busy have no effect.
- R9: A return (op 2'b10) traps as a control fault in user mode. Otherwise it reads cell 0 in the next cycle and restores pointer, base and length from it. The restored mode is the saved mode, with reserved read as user, limited to no higher than the mode that issued the return.
- R10: A memory cell packs the state with the mode in bits 49:48, the pointer in 47:32, the base in 31:16 and the length in 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction offered this cycle |
| req_op | input | 2 | 00/11 execute, 01 state write, 10 return |
| req_mem | input | 1 | Instruction makes a memory reference |
| req_off | input | 16 | Segment-relative offset of the reference |
| req_mode | input | 2 | Mode for a state write |
| req_base | input | 16 | Base for a state write |
| req_len | input | 16 | Length for a state write |
| busy | output | 1 | Trap or return sequence in progress |
| trap | output | 1 | Current request traps |
| phys_ok | output | 1 | Reference is inside the segment |
| phys_addr | output | 16 | Relocated address |
| cur_mode | output | 2 | Current mode |
| cur_pc | output | 16 | Current instruction pointer |
| cur_base | output | 16 | Current segment base |
| cur_len | output | 16 | Current segment length |
| syndrome | output | 2 | Causes of the most recent trap |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Cell address |
| mem_wdata | output | 50 | Packed state to write |
| mem_rdata | input | 50 | Packed state read, valid the cycle after a read |

## Verification
Trap, phys_ok and phys_addr are combinational, so the bench samples them one nanosecond after it drives a request, before the edge. A retired instruction shows its new state at the falling edge after the accepting edge. A trap shows the cell 0 write one falling edge later, the cell 1 read one edge after that, and the handler state three edges after acceptance. A return shows its cell 0 read one edge after acceptance and the restored state two edges after. The bench's task walks those falling edges in order and checks each result only in its own cycle. During the trap sequence it keeps a conflicting request on the port to show that busy blocks it.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    parameter int unsigned AW = 16;

    typedef enum logic [1:0] {
        M_USER = 2'b00,
        M_SUP  = 2'b01,
        M_ROOT = 2'b10,
        M_RSVD = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        OP_EXEC  = 2'b00,
        OP_SETST = 2'b01,
        OP_RET   = 2'b10,
        OP_EXEC2 = 2'b11
    } op_e;

    typedef struct packed {
        mode_e          mode;
        logic [AW-1:0]  pc;
        logic [AW-1:0]  base;
        logic [AW-1:0]  len;
    } cpu_st_t;

    localparam int unsigned SW = $bits(cpu_st_t);
    localparam logic [AW-1:0] SAVE_CELL = '0;
    localparam logic [AW-1:0] LOAD_CELL = AW'(1);

    typedef enum logic [2:0] {
        S_IDLE, S_SAVE, S_FETCH, S_APPLY, S_RFETCH, S_RAPPLY
    } seq_e;

    function automatic mode_e mode_up(mode_e m);
        return (m == M_USER) ? M_SUP : M_ROOT;
    endfunction

    function automatic mode_e mode_clamp(mode_e loaded, mode_e issuer);
        mode_e r;
        r = (loaded == M_RSVD) ? M_USER : loaded;
        if (r > issuer) r = issuer;
        return r;
    endfunction

endpackage

// File: rtl/tpc_bounds.sv
module tpc_bounds
    import tpc_pkg::*;
(
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] off,
    output logic          fault,
    output logic          ok,
    output logic [AW-1:0] phys
);
    always_comb begin
        fault = en && (off >= len);
        ok    = en && !(off >= len);
        phys  = base + off;
    end
endmodule

// File: rtl/tpc_priv.sv
module tpc_priv
    import tpc_pkg::*;
(
    input  mode_e cur,
    input  op_e   op,
    input  mode_e want,
    output logic  fault
);
    always_comb begin
        fault = 1'b0;
        unique case (op)
            OP_SETST: begin
                unique case (cur)
                    M_USER:  fault = 1'b1;
                    M_SUP:   fault = (want != M_USER);
                    default: fault = (want == M_RSVD);
                endcase
            end
            OP_RET:  fault = (cur == M_USER);
            default: fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/tpc_seq.sv
module tpc_seq
    import tpc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  op_e           op,
    input  cpu_st_t       wr_st,
    input  logic          mem_fault,
    input  logic          ctl_fault,
    input  logic [SW-1:0] rdata,
    output cpu_st_t       cur_q,
    output logic [1:0]    syn_q,
    output logic          busy,
    output logic          trap,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [SW-1:0] mem_wdata
);
    seq_e    st_q;
    cpu_st_t saved_q;
    cpu_st_t rd;
    logic    accept;

    assign rd     = cpu_st_t'(rdata);
    assign accept = (st_q == S_IDLE) && req_valid;
    assign trap   = accept && (mem_fault || ctl_fault);
    assign busy   = (st_q != S_IDLE);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            S_SAVE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = SAVE_CELL;
                mem_wdata = saved_q;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = LOAD_CELL;
            end
            S_RFETCH: begin
                mem_req  = 1'b1;
                mem_addr = SAVE_CELL;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            cur_q   <= '{mode: M_ROOT, pc: '0, base: '0, len: '1};
            saved_q <= '0;
            syn_q   <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: if (accept) begin
                    saved_q <= cur_q;
                    if (trap) begin
                        syn_q <= {ctl_fault, mem_fault};
                        st_q  <= S_SAVE;
                    end else begin
                        unique case (op)
                            OP_SETST: begin
                                cur_q.mode <= wr_st.mode;
                                cur_q.base <= wr_st.base;
                                cur_q.len  <= wr_st.len;
                                cur_q.pc   <= cur_q.pc + AW'(1);
                            end
                            OP_RET:  st_q <= S_RFETCH;
                            default: cur_q.pc <= cur_q.pc + AW'(1);
                        endcase
                    end
                end
                S_SAVE:   st_q <= S_FETCH;
                S_FETCH:  st_q <= S_APPLY;
                S_APPLY: begin
                    cur_q <= '{mode: mode_up(saved_q.mode), pc: rd.pc,
                               base: rd.base, len: rd.len};
                    st_q  <= S_IDLE;
                end
                S_RFETCH: st_q <= S_RAPPLY;
                S_RAPPLY: begin
                    cur_q <= '{mode: mode_clamp(rd.mode, saved_q.mode), pc: rd.pc,
                               base: rd.base, len: rd.len};
                    st_q  <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    p_save_after_trap_r6: assert property (@(posedge clk) disable iff (rst)
        trap |=> (mem_req && mem_we && mem_addr == SAVE_CELL && mem_wdata == $past(cur_q)));

    p_fetch_after_save_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (mem_req && !mem_we && mem_addr == LOAD_CELL));

    p_write_cell0_only_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == SAVE_CELL));

    p_mode_legal_r4: assert property (@(posedge clk) disable iff (rst)
        cur_q.mode != M_RSVD);

    p_syn_set_r5: assert property (@(posedge clk) disable iff (rst)
        trap |=> (syn_q != 2'b00));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> ($stable(cur_q) && busy));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && !trap && (op == OP_EXEC || op == OP_EXEC2))
        |=> (cur_q.pc == $past(cur_q.pc) + AW'(1) && $stable(cur_q.mode)));

endmodule

// File: rtl/tpc_top.sv
module tpc_top
    import tpc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          req_mem,
    input  logic [AW-1:0] req_off,
    input  logic [1:0]    req_mode,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_len,
    output logic          busy,
    output logic          trap,
    output logic          phys_ok,
    output logic [AW-1:0] phys_addr,
    output logic [1:0]    cur_mode,
    output logic [AW-1:0] cur_pc,
    output logic [AW-1:0] cur_base,
    output logic [AW-1:0] cur_len,
    output logic [1:0]    syndrome,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [SW-1:0] mem_wdata,
    input  logic [SW-1:0] mem_rdata
);
    cpu_st_t cur;
    cpu_st_t wr_st;
    logic    mem_fault;
    logic    ctl_fault;

    assign wr_st = '{mode: mode_e'(req_mode), pc: '0, base: req_base, len: req_len};

    tpc_bounds u_bounds (
        .en    (req_mem),
        .base  (cur.base),
        .len   (cur.len),
        .off   (req_off),
        .fault (mem_fault),
        .ok    (phys_ok),
        .phys  (phys_addr)
    );

    tpc_priv u_priv (
        .cur   (cur.mode),
        .op    (op_e'(req_op)),
        .want  (mode_e'(req_mode)),
        .fault (ctl_fault)
    );

    tpc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .op        (op_e'(req_op)),
        .wr_st     (wr_st),
        .mem_fault (mem_fault),
        .ctl_fault (ctl_fault),
        .rdata     (mem_rdata),
        .cur_q     (cur),
        .syn_q     (syndrome),
        .busy      (busy),
        .trap      (trap),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign cur_mode = cur.mode;
    assign cur_pc   = cur.pc;
    assign cur_base = cur.base;
    assign cur_len  = cur.len;

endmodule

// File: tb/tpc_top_tb_top.sv
module tpc_top_tb_top;
    import tpc_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst, req_valid, req_mem;
    logic [1:0]    req_op, req_mode;
    logic [AW-1:0] req_off, req_base, req_len;
    logic          busy, trap, phys_ok, mem_req, mem_we;
    logic [AW-1:0] phys_addr, cur_pc, cur_base, cur_len, mem_addr;
    logic [1:0]    cur_mode, syndrome;
    logic [SW-1:0] mem_wdata, mem_rdata;

    tpc_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_mem(req_mem), .req_off(req_off), .req_mode(req_mode),
        .req_base(req_base), .req_len(req_len), .busy(busy), .trap(trap),
        .phys_ok(phys_ok), .phys_addr(phys_addr), .cur_mode(cur_mode),
        .cur_pc(cur_pc), .cur_base(cur_base), .cur_len(cur_len),
        .syndrome(syndrome), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: cell 0 written by the block, cell 1 fixed handler state
    localparam cpu_st_t HANDLER = '{mode: M_RSVD, pc: 16'h0100, base: 16'h4000, len: 16'h0080};
    cpu_st_t cell0 = '0;
    logic [SW-1:0] rdq = '0;
    assign mem_rdata = rdq;
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_addr == 0) cell0 <= cpu_st_t'(mem_wdata);
            end else begin
                rdq <= (mem_addr == 0) ? SW'(cell0) : SW'(HANDLER);
            end
        end
    end

    int n_chk = 0, n_bad = 0;
    cpu_st_t exp_st, exp_c0;
    logic [1:0] exp_syn;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic bit exp_ctl(mode_e m, op_e op, mode_e want);
        if (op == OP_SETST) begin
            if (m == M_USER) return 1'b1;
            if (m == M_SUP)  return want != M_USER;
            return want == M_RSVD;
        end
        if (op == OP_RET) return m == M_USER;
        return 1'b0;
    endfunction

    task automatic check_state(input string req);
        chk(cur_mode == exp_st.mode, req, "mode", 64'(cur_mode), 64'(exp_st.mode));
        chk(cur_pc == exp_st.pc, req, "pc", 64'(cur_pc), 64'(exp_st.pc));
        chk(cur_base == exp_st.base && cur_len == exp_st.len, req, "segment",
            {32'(cur_base), 32'(cur_len)}, {32'(exp_st.base), 32'(exp_st.len)});
        chk(!busy, req, "busy low", 64'(busy), 64'd0);
        chk(syndrome == exp_syn, "R5", "syndrome", 64'(syndrome), 64'(exp_syn));
    endtask

    task automatic run_op(input op_e op, input bit mref, input logic [AW-1:0] off,
                          input logic [1:0] nm, input logic [AW-1:0] nb,
                          input logic [AW-1:0] nl, input string req);
        bit mf, cf, tr;
        mode_e m;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_mem = mref; req_off = off;
        req_mode = nm; req_base = nb; req_len = nl;
        mf = mref && (off >= exp_st.len);
        cf = exp_ctl(exp_st.mode, op, mode_e'(nm));
        tr = mf || cf;
        #1;
        chk(trap == tr, "R5", "trap flag", 64'(trap), 64'(tr));
        if (mref && !mf)
            chk(phys_ok && phys_addr == AW'(exp_st.base + off), "R3", "phys",
                {32'(phys_ok), 32'(phys_addr)}, {32'd1, 32'(AW'(exp_st.base + off))});
        if (mref && mf)
            chk(!phys_ok, "R3", "phys_ok low on fault", 64'(phys_ok), 64'd0);
        @(negedge clk);
        if (tr) begin
            // conflicting request held while busy (R8)
            req_op = OP_SETST; req_mode = 2'b00; req_mem = 1'b0;
            chk(busy && mem_req && mem_we && mem_addr == 0, "R6", "save write to cell 0",
                {61'd0, busy, mem_we, mem_req}, 64'd7);
            chk(cpu_st_t'(mem_wdata) == exp_st, "R10", "saved packing",
                64'(mem_wdata), 64'(SW'(exp_st)));
            @(negedge clk);
            chk(busy && mem_req && !mem_we && mem_addr == 1, "R6", "load read of cell 1",
                {32'(mem_addr), 29'd0, busy, mem_we, mem_req}, {32'd1, 32'd5});
            req_valid = 1'b0;
            @(negedge clk);
            chk(busy, "R8", "busy during load", 64'(busy), 64'd1);
            @(negedge clk);
            exp_c0  = exp_st;
            exp_syn = {cf, mf};
            exp_st  = '{mode: mode_up(exp_st.mode), pc: HANDLER.pc,
                        base: HANDLER.base, len: HANDLER.len};
            check_state("R7");
        end else begin
            req_valid = 1'b0;
            if (op == OP_RET) begin
                chk(busy && mem_req && !mem_we && mem_addr == 0, "R9", "restore read cell 0",
                    {32'(mem_addr), 29'd0, busy, mem_we, mem_req}, {32'd0, 32'd5});
                @(negedge clk);
                @(negedge clk);
                m = exp_c0.mode == M_RSVD ? M_USER : exp_c0.mode;
                if (m > exp_st.mode) m = exp_st.mode;
                exp_st = '{mode: m, pc: exp_c0.pc, base: exp_c0.base, len: exp_c0.len};
                check_state("R9");
            end else if (op == OP_SETST) begin
                exp_st = '{mode: mode_e'(nm), pc: exp_st.pc + 1'b1, base: nb, len: nl};
                check_state("R4");
            end else begin
                exp_st.pc = exp_st.pc + 1'b1;
                check_state(req);
            end
        end
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; req_valid = 1'b0; req_op = 2'b00; req_mem = 1'b0;
        req_off = '0; req_mode = '0; req_base = '0; req_len = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_st = '{mode: M_ROOT, pc: '0, base: '0, len: '1};
        exp_c0 = '0; exp_syn = 2'b00;
        @(negedge clk);
        check_state("R1");

        // directed corners
        run_op(OP_EXEC, 1'b1, 16'h0010, 2'b00, '0, '0, "R2");
        run_op(OP_SETST, 1'b0, '0, 2'b01, 16'hFFF0, 16'h0040, "R4");   // root -> supervisor
        run_op(OP_EXEC, 1'b1, 16'h0020, 2'b00, '0, '0, "R3");           // wraps past top
        run_op(OP_EXEC, 1'b1, 16'h003F, 2'b00, '0, '0, "R3");           // last in range
        run_op(OP_EXEC, 1'b1, 16'h0040, 2'b00, '0, '0, "R3");           // offset == length: trap to root
        run_op(OP_RET, 1'b0, '0, 2'b00, '0, '0, "R9");                  // back to supervisor
        run_op(OP_SETST, 1'b0, '0, 2'b01, 16'h1000, 16'h0010, "R4");   // supervisor writes supervisor: trap
        run_op(OP_SETST, 1'b0, '0, 2'b00, 16'h2000, 16'h0008, "R4");   // root drops to user
        run_op(OP_SETST, 1'b1, 16'h0009, 2'b10, '0, '0, "R5");          // both causes from user
        run_op(OP_SETST, 1'b0, '0, 2'b11, '0, '0, "R4");                // reserved from supervisor
        run_op(OP_EXEC2, 1'b0, '0, 2'b00, '0, '0, "R2");
        run_op(OP_SETST, 1'b0, '0, 2'b11, '0, '0, "R4");                // reserved from root
        run_op(OP_RET, 1'b0, '0, 2'b00, '0, '0, "R9");

        // constrained random
        for (int i = 0; i < 400; i++) begin
            op_e op;
            int r;
            logic [AW-1:0] off;
            r = $urandom % 10;
            op = (r < 4) ? OP_EXEC : (r < 7) ? OP_SETST : (r < 9) ? OP_RET : OP_EXEC2;
            off = AW'($urandom % (32'(exp_st.len) + 4));
            run_op(op, 1'($urandom % 2), off, 2'($urandom % 4), AW'($urandom),
                   AW'(1 + $urandom % 64), "R2");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule